// File: doc/BRIEF.md
# Preloadable 8-bit Timer Counter

This block is an up-counting timer with a reload value held in a separate preload register. Software reaches it over a small register bus with one address for the count, one for control and one for the interrupt flag. While the timer runs, each single-cycle count tick advances the count by one. When the count is at its maximum, the next tick reloads the count from the preload register and sets a sticky interrupt request flag.

A write to the count address always updates the preload register. It also reaches the live count, but only while the timer is stopped. A running count therefore picks up a new reload value only at its next wrap. Reading the count address suppresses that cycle's tick, so the value read cannot change while it is being read. A tick suppressed this way is lost and is not counted later.

All logic runs on one system clock and uses a synchronous active-low reset.

Top module: `preload_timer8`

## Requirements
- R1: While the run bit is 1, each cycle with `tick_i` high and no read of the count address (address 0) raises the count by one.
- R2: While the run bit is 0, `tick_i` has no effect on the count.
- R3: The run bit is bit 4 of the control register at address 1. It is written through `wdata_i[4]` and read back on `rdata_o[4]`, with every other bit of that read returning 0.
- R4: While the run bit is 0, a write to address 0 loads the written value into both the preload register and the count.
- R5: While the run bit is 1, a write to address 0 changes only the preload register. The count continues from its present value, and the new preload value is used at the next wrap.
- R6: A counted tick taken while the count is 0xFF makes the count equal to the preload value after that clock edge. The same edge sets the interrupt flag.
- R7: In a cycle where `rd_i` is high with address 0, `rdata_o` shows the count and that cycle's tick is dropped for good.
- R8: The interrupt flag drives `irq_o` and reads back as bit 5 at address 2. It stays set until a write to address 2 with `wdata_i[5]`=0. A write with that bit at 1 has no effect on the flag.
- R9: If a wrap and a clearing write to address 2 fall in the same cycle, the flag ends up set.
- R10: Reset clears the count, the preload register, the run bit and the flag. `rdata_o` is 0 whenever `rd_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Single-cycle count enable |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register select: 0 count, 1 control, 2 interrupt flag |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid while `rd_i` is high |
| irq_o | output | 1 | Sticky interrupt request |

## Verification
Two pairs of functions can land in the same cycle, and each pair has a defined winner.

- **Count read with a tick.** A read of the count address is issued together with a tick. The bench checks the value read in that cycle. It then reads again to confirm that the tick was lost and that counting resumes from the unchanged value.
- **Wrap with a clearing write.** The count is parked at 0xFF while stopped, and the timer is started. A clearing write to the flag address is then issued in the same cycle as the wrapping tick. The bench judges this case by `irq_o` after that edge and by the reloaded count.

// File: rtl/tmr8_pkg.sv
// Shared register selector for the preloadable timer.
// Assumes a two-bit register address space.
package tmr8_pkg;
    typedef enum logic [1:0] {
        REG_COUNT = 2'd0,
        REG_CTRL  = 2'd1,
        REG_INTC  = 2'd2,
        REG_NONE  = 2'd3
    } tmr_reg_e;
endpackage

// File: rtl/tmr8_bus_decode.sv
// Turns the bus strobes and the address into one strobe per register action.
// Assumes at most one access type per address in any cycle is meaningful.
module tmr8_bus_decode
    import tmr8_pkg::*;
(
    input  logic       wr_i,
    input  logic       rd_i,
    input  logic [1:0] addr_i,
    output logic       wr_count_o,
    output logic       wr_ctrl_o,
    output logic       wr_intc_o,
    output logic       rd_count_o
);
    tmr_reg_e sel;

    // Decode the address into per-register strobes.
    always_comb begin
        sel        = tmr_reg_e'(addr_i);
        wr_count_o = wr_i && (sel == REG_COUNT);
        wr_ctrl_o  = wr_i && (sel == REG_CTRL);
        wr_intc_o  = wr_i && (sel == REG_INTC);
        rd_count_o = rd_i && (sel == REG_COUNT);
    end
endmodule

// File: rtl/tmr8_counter.sv
// Holds the count and the preload value. It steps on a tick while running,
// and wraps from the maximum value back to the preload value.
// A reload write reaches the count only while the timer is stopped.
// Assumes tick_i is a single-cycle pulse in the clk domain.
module tmr8_counter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             hold_i,
    input  logic             wr_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] count_o,
    output logic [WIDTH-1:0] preload_o,
    output logic             wrap_o
);
    localparam logic [WIDTH-1:0] MAXV = {WIDTH{1'b1}};

    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] pre_q;
    logic             step;

    // A tick counts only while running and while no read holds the count.
    always_comb begin
        step   = run_i && tick_i && !hold_i;
        wrap_o = step && (cnt_q == MAXV);
    end

    // Preload register: every write lands here.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pre_q <= '0;
        else if (wr_i)
            pre_q <= wdata_i;
    end

    // Count register: a direct load while stopped, otherwise step or wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (wr_i && !run_i)
            cnt_q <= wdata_i;
        else if (wrap_o)
            cnt_q <= pre_q;
        else if (step)
            cnt_q <= cnt_q + 1'b1;
    end

    assign count_o   = cnt_q;
    assign preload_o = pre_q;
endmodule

// File: rtl/tmr8_irq_flag.sv
// Sticky interrupt request flag.
// A set event wins over a software clear that arrives in the same cycle.
// Software can clear the flag but cannot set it.
module tmr8_irq_flag #(
    parameter int WIDTH    = 8,
    parameter int FLAG_BIT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic             wr_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic             flag_o
);
    logic clr;

    // A clear needs a write with the flag bit at zero.
    always_comb clr = wr_i && !wdata_i[FLAG_BIT];

    // Flag state: a set has priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_o <= 1'b0;
        else if (set_i)
            flag_o <= 1'b1;
        else if (clr)
            flag_o <= 1'b0;
    end
endmodule

// File: rtl/preload_timer8.sv
// Preloadable timer top level. It ties together the bus decode, the
// counter, the run bit and the interrupt flag, and it multiplexes read data.
// Assumes a single clock domain and a synchronous active-low reset.
module preload_timer8
    import tmr8_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter int RUN_BIT  = 4,
    parameter int FLAG_BIT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             wr_i,
    input  logic             rd_i,
    input  logic [1:0]       addr_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] rdata_o,
    output logic             irq_o
);
    logic             wr_count, wr_ctrl, wr_intc, rd_count;
    logic             run_q;
    logic             wrap;
    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] pre_q;

    tmr8_bus_decode u_dec (
        .wr_i       (wr_i),
        .rd_i       (rd_i),
        .addr_i     (addr_i),
        .wr_count_o (wr_count),
        .wr_ctrl_o  (wr_ctrl),
        .wr_intc_o  (wr_intc),
        .rd_count_o (rd_count)
    );

    // Run bit held in the control register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= 1'b0;
        else if (wr_ctrl)
            run_q <= wdata_i[RUN_BIT];
    end

    tmr8_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run_q),
        .tick_i    (tick_i),
        .hold_i    (rd_count),
        .wr_i      (wr_count),
        .wdata_i   (wdata_i),
        .count_o   (cnt_q),
        .preload_o (pre_q),
        .wrap_o    (wrap)
    );

    tmr8_irq_flag #(.WIDTH(WIDTH), .FLAG_BIT(FLAG_BIT)) u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (wrap),
        .wr_i    (wr_intc),
        .wdata_i (wdata_i),
        .flag_o  (irq_o)
    );

    // Read data multiplexer: zero when idle or when no register is selected.
    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            case (tmr_reg_e'(addr_i))
                REG_COUNT: rdata_o = cnt_q;
                REG_CTRL:  rdata_o[RUN_BIT]  = run_q;
                REG_INTC:  rdata_o[FLAG_BIT] = irq_o;
                default:   rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/tmr8_chk.sv
// Property checker for preload_timer8, attached with bind.
// Assumes it sees the internal count, preload, run bit and strobes.
module tmr8_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_i,
    input logic             wr_i,
    input logic [1:0]       addr_i,
    input logic [WIDTH-1:0] wdata_i,
    input logic             rd_count,
    input logic             wr_count,
    input logic             wr_intc,
    input logic             run_q,
    input logic [WIDTH-1:0] cnt_q,
    input logic [WIDTH-1:0] pre_q,
    input logic             irq_o
);
    localparam logic [WIDTH-1:0] MAXV = {WIDTH{1'b1}};

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !wr_count) |=> $stable(cnt_q)); // R2
    AST_READ_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_count && !wr_count) |=> $stable(cnt_q)); // R7
    AST_WRAP_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && tick_i && !rd_count && cnt_q == MAXV) |=> (cnt_q == $past(pre_q)) && irq_o); // R6
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && tick_i && !rd_count && cnt_q == MAXV && wr_intc) |=> irq_o); // R9
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !(wr_intc && !wdata_i[5])) |=> irq_o); // R8
    AST_RUNNING_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && wr_count) |=> (pre_q == $past(wdata_i))); // R5
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && tick_i && !rd_count && !wr_count && cnt_q != MAXV) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R1
endmodule

bind preload_timer8 tmr8_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .wr_i     (wr_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rd_count (rd_count),
    .wr_count (wr_count),
    .wr_intc  (wr_intc),
    .run_q    (run_q),
    .cnt_q    (cnt_q),
    .pre_q    (pre_q),
    .irq_o    (irq_o)
);

// File: tb/tb_preload_timer8.sv
// Self-checking bench: a vector table walk, then directed corner cases.
module tb_preload_timer8;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       wr_i = 1'b0;
    logic       rd_i = 1'b0;
    logic [1:0] addr_i = 2'd0;
    logic [7:0] wdata_i = 8'h00;
    logic [7:0] rdata_o;
    logic       irq_o;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    preload_timer8 dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .wr_i    (wr_i),
        .rd_i    (rd_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o),
        .irq_o   (irq_o)
    );

    // Row fields: req[4], wr, rd, addr[2], wdata[8], tick, chk, exp_rd[8], exp_irq
    localparam int NV = 25;
    localparam logic [26:0] VEC [NV] = '{
        {4'd4,  1'b1,1'b0,2'd0,8'hFC,1'b0,1'b0,8'h00,1'b0}, // R4 load while stopped
        {4'd4,  1'b0,1'b1,2'd0,8'h00,1'b0,1'b1,8'hFC,1'b0}, // R4
        {4'd3,  1'b1,1'b0,2'd1,8'h10,1'b0,1'b0,8'h00,1'b0}, // R3 start
        {4'd3,  1'b0,1'b1,2'd1,8'h00,1'b0,1'b1,8'h10,1'b0}, // R3 readback
        {4'd1,  1'b0,1'b0,2'd0,8'h00,1'b1,1'b0,8'h00,1'b0}, // R1 FD
        {4'd1,  1'b0,1'b0,2'd0,8'h00,1'b1,1'b0,8'h00,1'b0}, // R1 FE
        {4'd7,  1'b0,1'b1,2'd0,8'h00,1'b1,1'b1,8'hFE,1'b0}, // R7 read with tick
        {4'd7,  1'b0,1'b1,2'd0,8'h00,1'b0,1'b1,8'hFE,1'b0}, // R7 tick lost
        {4'd1,  1'b0,1'b0,2'd0,8'h00,1'b1,1'b0,8'h00,1'b0}, // R1 FF
        {4'd1,  1'b0,1'b1,2'd0,8'h00,1'b0,1'b1,8'hFF,1'b0}, // R1
        {4'd6,  1'b0,1'b0,2'd0,8'h00,1'b1,1'b0,8'h00,1'b1}, // R6 wrap
        {4'd6,  1'b0,1'b1,2'd0,8'h00,1'b0,1'b1,8'hFC,1'b1}, // R6 reloaded
        {4'd5,  1'b1,1'b0,2'd0,8'h80,1'b0,1'b0,8'h00,1'b1}, // R5 write while running
        {4'd5,  1'b0,1'b1,2'd0,8'h00,1'b0,1'b1,8'hFC,1'b1}, // R5 count untouched
        {4'd5,  1'b0,1'b0,2'd0,8'h00,1'b1,1'b0,8'h00,1'b1}, // FD
        {4'd5,  1'b0,1'b0,2'd0,8'h00,1'b1,1'b0,8'h00,1'b1}, // FE
        {4'd5,  1'b0,1'b0,2'd0,8'h00,1'b1,1'b0,8'h00,1'b1}, // FF
        {4'd5,  1'b0,1'b0,2'd0,8'h00,1'b1,1'b0,8'h00,1'b1}, // wrap to new value
        {4'd5,  1'b0,1'b1,2'd0,8'h00,1'b0,1'b1,8'h80,1'b1}, // R5 new preload used
        {4'd8,  1'b0,1'b1,2'd2,8'h00,1'b0,1'b1,8'h20,1'b1}, // R8 flag readback
        {4'd8,  1'b1,1'b0,2'd2,8'h00,1'b0,1'b0,8'h00,1'b0}, // R8 clear
        {4'd8,  1'b1,1'b0,2'd2,8'h20,1'b0,1'b0,8'h00,1'b0}, // R8 writing one: no set
        {4'd8,  1'b0,1'b1,2'd2,8'h00,1'b0,1'b1,8'h00,1'b0}, // R8
        {4'd1,  1'b0,1'b0,2'd0,8'h00,1'b1,1'b0,8'h00,1'b0}, // R1 81
        {4'd1,  1'b0,1'b1,2'd0,8'h00,1'b0,1'b1,8'h81,1'b0}  // R1
    };

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one bus cycle at the falling edge; returns after the next rising edge plus 1 ns.
    task automatic cycle(input logic w, input logic r, input logic [1:0] a, input logic [7:0] d, input logic t);
        @(negedge clk);
        wr_i = w; rd_i = r; addr_i = a; wdata_i = d; tick_i = t;
        @(posedge clk);
        #1;
        wr_i = 1'b0; rd_i = 1'b0; tick_i = 1'b0;
    endtask

    task automatic read_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        rd_i = 1'b1; addr_i = a;
        #1;
        check(req, "read", rdata_o, exp);
        @(posedge clk);
        #1;
        rd_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R10 reset state
        check("R10", "irq after reset", {7'd0, irq_o}, 8'h00);
        check("R10", "idle rdata", rdata_o, 8'h00);
        read_chk(2'd0, 8'h00, "R10");
        read_chk(2'd1, 8'h00, "R10");

        for (int i = 0; i < NV; i++) begin
            logic [26:0] v;
            string rq;
            v  = VEC[i];
            rq = $sformatf("R%0d", v[26:23]);
            @(negedge clk);
            wr_i = v[22]; rd_i = v[21]; addr_i = v[20:19]; wdata_i = v[18:11]; tick_i = v[10];
            #1;
            if (v[9]) check(rq, "table read", rdata_o, v[8:1]);
            @(posedge clk);
            #1;
            wr_i = 1'b0; rd_i = 1'b0; tick_i = 1'b0;
            check(rq, "table irq", {7'd0, irq_o}, {7'd0, v[0]});
        end

        // R2: stopped timer ignores ticks
        cycle(1'b1, 1'b0, 2'd1, 8'h00, 1'b0);
        for (int k = 0; k < 4; k++) cycle(1'b0, 1'b0, 2'd0, 8'h00, 1'b1);
        read_chk(2'd0, 8'h81, "R2");

        // R9: wrap and clearing write in the same cycle
        cycle(1'b1, 1'b0, 2'd0, 8'hFF, 1'b0);
        cycle(1'b1, 1'b0, 2'd1, 8'h10, 1'b0);
        cycle(1'b1, 1'b0, 2'd2, 8'h00, 1'b1);
        check("R9", "flag after set/clear clash", {7'd0, irq_o}, 8'h01);
        read_chk(2'd0, 8'hFF, "R9");

        // R10: reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        check("R10", "irq after mid reset", {7'd0, irq_o}, 8'h00);
        read_chk(2'd0, 8'h00, "R10");
        read_chk(2'd1, 8'h00, "R10");
        cycle(1'b0, 1'b0, 2'd0, 8'h00, 1'b1);
        read_chk(2'd0, 8'h00, "R10");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule